// File: doc/BRIEF.md
# Two-Wire Bus Idle Timeout Detector

This block watches the clock and data lines of a two-wire bus, after they have been brought into the system clock domain. It reports the bus as free once both lines have stayed high for more than a set number of ticks. The ticks come from one of four timer strobes, and a two-bit select picks which one. Detection only runs while its enable is set. If no ticks arrive, the block never reports the bus as free, even when only slave operation is in use.

A master that wants to start a transfer raises a request for one cycle. The block holds that request as pending. In the cycle where the bus is free and a request is pending, the block emits a one-cycle launch pulse, and the pending request is dropped. Generating the START waveform, driving the lines and the timers themselves all lie outside this block.

Top module: `bus_free_detect`

## Requirements
- R1: With the enable set and both lines held high, the free flag rises in the cycle after the edge that takes in the eleventh selected tick. It is still low after ten ticks. The threshold is the parameter FREE_TICKS, which defaults to 10, and the flag needs FREE_TICKS+1 ticks.
- R2: While the enable input is low, the free flag stays low whatever ticks arrive. A count reached while the enable is low is not kept.
- R3: When a request is pending and the free flag is high, the launch output is high in that same cycle. This covers a request that was pending before the timeout expired, so the pulse comes in the first free cycle. A request raised while the bus is already free is launched in the next cycle.
- R4: When no selected ticks arrive, the free flag never rises, however long both lines stay high.
- R5: The select input picks the tick strobe by value: 0 picks tick_tmr_a, 1 picks tick_tmr_b, 2 picks tick_tmr_c_hi and 3 picks tick_tmr_c_lo. Strobes that are not selected do not advance the count.
- R6: Whenever either line is low (this includes the data line falling while the clock line is high, which is a START), the high-time count returns to zero. A full run of FREE_TICKS+1 ticks is then needed again.
- R7: The count saturates. Once the bus is free, any number of further ticks leaves it free.
- R8: The free flag falls in the same cycle that either line goes low.
- R9: The launch output is high for exactly one system clock for each request. After the pulse the request is no longer pending, so no second pulse follows without a new request.
- R10: While reset is asserted and right after it, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_in | input | 1 | Synchronized clock-line level |
| sda_in | input | 1 | Synchronized data-line level |
| free_en | input | 1 | Enables bus-free detection |
| tick_sel | input | 2 | Selects the tick strobe (see R5) |
| tick_tmr_a | input | 1 | Tick strobe from timer A overflow |
| tick_tmr_b | input | 1 | Tick strobe from timer B overflow |
| tick_tmr_c_hi | input | 1 | Tick strobe from timer C high-byte overflow |
| tick_tmr_c_lo | input | 1 | Tick strobe from timer C low-byte overflow |
| start_req | input | 1 | One-cycle master START request |
| bus_free | output | 1 | Bus is free |
| start_go | output | 1 | One-cycle START launch pulse |

## Verification
Both outputs are combinational. They are formed from the line levels and enable in the current cycle, together with the registered count and pending request. As a result, the free flag falls in the cycle where a line drops, and it rises one cycle after the edge that takes in the final tick. The launch pulse shares a cycle with the free flag whenever a request was already pending. Each bench cycle drives new inputs shortly after the falling clock edge and samples the outputs one nanosecond later, before the next rising edge. The bench's reference model moves its own count and pending flag forward only at that rising edge, so the expected value for each cycle matches the register timing described above.

// File: rtl/bus_free_detect.sv
module bus_free_detect #(
  parameter int FREE_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic       free_en,
  input  logic [1:0] tick_sel,
  input  logic       tick_tmr_a,
  input  logic       tick_tmr_b,
  input  logic       tick_tmr_c_hi,
  input  logic       tick_tmr_c_lo,
  input  logic       start_req,
  output logic       bus_free,
  output logic       start_go
);

  localparam int LIMIT = FREE_TICKS + 1;
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic [3:0]    ticks;
  logic          tick;
  logic          idle;

  assign ticks = {tick_tmr_c_lo, tick_tmr_c_hi, tick_tmr_b, tick_tmr_a};
  assign tick  = ticks[tick_sel];
  assign idle  = scl_in & sda_in & free_en;

  assign bus_free = idle & (cnt_q == LIM);
  assign start_go = bus_free & pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!idle)
      cnt_q <= '0;
    else if (tick && cnt_q != LIM)
      cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= 1'b0;
    else if (start_go)
      pend_q <= 1'b0;
    else if (start_req)
      pend_q <= 1'b1;
  end

  a_r1_free_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(tick));

  a_r2_disabled_not_free: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |-> !bus_free);

  a_r6_low_clears_count: assert property (@(posedge clk) disable iff (!rst_n)
    !(scl_in && sda_in) |=> cnt_q == '0);

  a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);

  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !start_go && !pend_q);

endmodule

// File: tb/bus_free_detect_test.sv
module bus_free_detect_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1, sda_in = 1'b1, free_en = 1'b0;
  logic [1:0] tick_sel = 2'd0;
  logic [3:0] tk = 4'd0;
  logic       start_req = 1'b0;
  logic       bus_free, start_go;

  int checks = 0;
  int fails = 0;
  logic s_free, s_go;

  int  m_cnt = 0;
  bit  m_pend = 1'b0;
  localparam int THR = 11;

  always #2 clk = ~clk;

  bus_free_detect uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .free_en(free_en), .tick_sel(tick_sel),
    .tick_tmr_a(tk[0]), .tick_tmr_b(tk[1]), .tick_tmr_c_hi(tk[2]), .tick_tmr_c_lo(tk[3]),
    .start_req(start_req), .bus_free(bus_free), .start_go(start_go)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_free(input bit scl, input bit sda, input bit en, input int cnt);
    return scl && sda && en && cnt == THR;
  endfunction

  task automatic cyc(input bit scl, input bit sda, input bit en, input bit [1:0] sel,
                     input bit [3:0] ticks, input bit req, input string tag);
    bit f, g;
    @(negedge clk);
    scl_in = scl; sda_in = sda; free_en = en; tick_sel = sel; tk = ticks; start_req = req;
    #1;
    s_free = bus_free; s_go = start_go;
    f = exp_free(scl, sda, en, m_cnt);
    g = f && m_pend;
    check({tag, " free"}, s_free, f);
    check({tag, " go"}, s_go, g);
    @(posedge clk);
    if (!(scl && sda && en)) m_cnt = 0;
    else if (ticks[sel] && m_cnt < THR) m_cnt++;
    if (g) m_pend = 1'b0;
    else if (req) m_pend = 1'b1;
  endtask

  task automatic clear_bus(input bit [1:0] sel);
    cyc(1'b0, 1'b1, 1'b1, sel, 4'd0, 1'b0, "R6");
  endtask

  initial begin
    #(4 * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got hang expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    #1;
    check("R10 reset free", bus_free, 1'b0);
    check("R10 reset go", start_go, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 2'd0, 4'd0, 1'b0, "R10");
    check("R10 after reset free", s_free, 1'b0);

    // R1: ten ticks not enough, eleventh frees
    clear_bus(2'd0);
    repeat (10) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R1");
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R1");
    check("R1 ten ticks", s_free, 1'b0);
    cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R1");
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R1");
    check("R1 eleven ticks", s_free, 1'b1);

    // R8: drop same cycle
    cyc(0, 1, 1, 2'd0, 4'd0, 0, "R8");
    check("R8 scl low drops", s_free, 1'b0);

    // R6: partial count lost on START (sda falls with scl high)
    repeat (7) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R6");
    cyc(1, 0, 1, 2'd0, 4'd0, 0, "R6");
    repeat (10) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R6");
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R6");
    check("R6 restart needed", s_free, 1'b0);
    cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R6");
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R6");
    check("R6 full run frees", s_free, 1'b1);
    cyc(1, 0, 1, 2'd0, 4'd0, 0, "R8");
    check("R8 sda low drops", s_free, 1'b0);

    // R7: saturation
    clear_bus(2'd0);
    repeat (300) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R7");
    check("R7 still free", s_free, 1'b1);

    // R4: no ticks
    clear_bus(2'd0);
    repeat (60) cyc(1, 1, 1, 2'd0, 4'd0, 0, "R4");
    check("R4 no ticks", s_free, 1'b0);

    // R5: select encoding
    for (int s = 0; s < 4; s++) begin
      clear_bus(2'(s));
      repeat (20) cyc(1, 1, 1, 2'(s), ~(4'b0001 << s), 0, "R5");
      check("R5 other strobes ignored", s_free, 1'b0);
      repeat (11) cyc(1, 1, 1, 2'(s), 4'b0001 << s, 0, "R5");
      cyc(1, 1, 1, 2'(s), 4'd0, 0, "R5");
      check("R5 selected strobe frees", s_free, 1'b1);
    end

    // R2: disabled
    clear_bus(2'd0);
    repeat (20) cyc(1, 1, 0, 2'd0, 4'b1111, 0, "R2");
    check("R2 disabled", s_free, 1'b0);
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R2");
    check("R2 count not kept", s_free, 1'b0);

    // R3/R9: pending start launched at timeout
    clear_bus(2'd0);
    cyc(0, 1, 1, 2'd0, 4'd0, 1, "R3");
    repeat (11) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R3");
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R3");
    check("R3 free at timeout", s_free, 1'b1);
    check("R3 launch at timeout", s_go, 1'b1);
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R9");
    check("R9 pulse one cycle", s_go, 1'b0);
    repeat (5) cyc(1, 1, 1, 2'd0, 4'b0001, 0, "R9");
    check("R9 no second pulse", s_go, 1'b0);
    cyc(1, 1, 1, 2'd0, 4'd0, 1, "R3");
    check("R3 request while free waits", s_go, 1'b0);
    cyc(1, 1, 1, 2'd0, 4'd0, 0, "R3");
    check("R3 request while free next cycle", s_go, 1'b1);

    // random phase checked against the reference model
    for (int i = 0; i < 20000; i++) begin
      bit sc, sd, en, rq;
      bit [3:0] t;
      sc = ($urandom_range(0, 99) < 97);
      sd = ($urandom_range(0, 99) < 97);
      en = ($urandom_range(0, 99) < 95);
      rq = ($urandom_range(0, 99) < 3);
      t  = 4'($urandom) & 4'($urandom);
      cyc(sc, sd, en, 2'($urandom_range(0, 3)), t, rq, "R1 R3 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule